// File: doc/BRIEF.md
# Spectrum Magnitude Normalizer

This block turns one complex transform bin into a single-sided amplitude value. Each accepted beat carries a signed two's-complement real part, a signed imaginary part and the index of the bin. The block squares and adds the two parts into an unsigned sum. It then extracts the integer square root of that sum with a restoring shift-and-subtract loop that settles one root bit per clock. Last, it divides the root by the transform length, or by half of it, depending on the bin.

The transform length is a power of two, so both divisions are plain right shifts. The DC bin, index 0, is shifted right by log2(N). Every other bin is shifted by log2(N)-1, which doubles its weight and folds the mirrored half of the spectrum into it. The unit handles one sample at a time. While it computes, it raises a busy flag and ignores its input strobe. The result leaves on a one-cycle valid pulse and stays on the output until the next result.

Top module: `spec_mag_norm`

## Requirements
- R1: After reset, `out_valid` is 0, `busy` is 0 and `out_mag` is 0.
- R2: For a bin index other than 0, `out_mag` equals floor(sqrt(re*re + im*im)) shifted right by N_LOG2-1 (9 at the defaults). `in_re` and `in_im` are read as signed two's complement, and the full range is allowed, including -2^(DATA_W-1) on both parts.
- R3: For bin index 0, `out_mag` equals floor(sqrt(re*re + im*im)) shifted right by N_LOG2 (10 at the defaults).
- R4: A sample is accepted on a rising edge where `in_valid` is 1 and `busy` is 0. `out_valid` then rises exactly DATA_W clock edges later (32 at the defaults) and stays high for one cycle only.
- R5: `busy` is 1 from the edge after acceptance until the edge that raises `out_valid`. While `busy` is 1, `in_valid` is ignored: it produces no extra result and does not change the pending one.
- R6: The bin index is captured at acceptance. Changes on `in_bin` after acceptance do not alter the scale applied to that sample.
- R7: A new sample may be accepted in the same cycle that `out_valid` is high, so back-to-back results are DATA_W+1 cycles apart.
- R8: `out_mag` changes only on the edge that raises `out_valid`, and it holds its value in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe for a sample |
| in_re | input | DATA_W | Real part, signed |
| in_im | input | DATA_W | Imaginary part, signed |
| in_bin | input | N_LOG2 | Bin index of the sample |
| busy | output | 1 | A computation is in progress |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_mag | output | DATA_W | Scaled magnitude, unsigned |

## Verification
The bench uses the default parameters, DATA_W = 32 and N_LOG2 = 10, which correspond to a 1024-point transform. At 32 bits the most negative operand pair drives the sum of squares to exactly 2^63. That case exercises the top bit of the 64-bit radicand and the widest remainder of the root loop. With a depth of 10 the two shift amounts differ by one bit, and seeded random operands show that difference across bin 0 and non-zero bins. The same settings also cover the 32-cycle latency and the 33-cycle spacing of back-to-back results.

// File: rtl/spec_mag_norm.sv
module spec_mag_norm #(
  parameter int DATA_W = 32,
  parameter int N_LOG2 = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  input  logic [N_LOG2-1:0]        in_bin,
  output logic                     busy,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_mag
);
  localparam int SQ_W  = 2 * DATA_W;
  localparam int REM_W = DATA_W + 2;
  localparam int CNT_W = $clog2(DATA_W);
  localparam int SH_DC = N_LOG2;
  localparam int SH_AC = N_LOG2 - 1;

  logic                   dc_q;
  logic [CNT_W-1:0]       step;
  logic [SQ_W-1:0]        rad;
  logic [REM_W-1:0]       rem;
  logic [DATA_W-1:0]      root;

  logic signed [SQ_W-1:0] re_sq, im_sq;
  logic [SQ_W-1:0]        sum_sq;
  logic [REM_W+1:0]       rem_t, trial;
  logic                   ge;
  logic [REM_W-1:0]       rem_nx;
  logic [DATA_W-1:0]      root_nx;
  logic                   accept, last;

  assign accept  = in_valid && !busy;
  assign last    = busy && (step == CNT_W'(DATA_W - 1));

  assign re_sq   = in_re * in_re;
  assign im_sq   = in_im * in_im;
  assign sum_sq  = $unsigned(re_sq) + $unsigned(im_sq);

  assign rem_t   = {rem, rad[SQ_W-1 -: 2]};
  assign trial   = {2'b00, root, 2'b01};
  assign ge      = rem_t >= trial;
  assign rem_nx  = REM_W'(ge ? rem_t - trial : rem_t);
  assign root_nx = {root[DATA_W-2:0], ge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_mag   <= '0;
      dc_q      <= 1'b0;
      step      <= '0;
      rad       <= '0;
      rem       <= '0;
      root      <= '0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        step <= '0;
        rad  <= sum_sq;
        rem  <= '0;
        root <= '0;
        dc_q <= (in_bin == '0);
      end else if (busy) begin
        rad  <= {rad[SQ_W-3:0], 2'b00};
        rem  <= rem_nx;
        root <= root_nx;
        step <= step + 1'b1;
        if (last) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_mag   <= dc_q ? (root_nx >> SH_DC) : (root_nx >> SH_AC);
        end
      end
    end
  end
endmodule

// File: rtl/spec_mag_norm_chk.sv
module spec_mag_norm_chk #(
  parameter int DATA_W = 32,
  parameter int N_LOG2 = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              busy,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_mag
);
  localparam int LAT_W = $clog2(DATA_W + 1) + 1;
  localparam int SH_AC = N_LOG2 - 1;

  logic [LAT_W-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat <= '0;
    else if (in_valid && !busy) lat <= '0;
    else if (busy)              lat <= lat + 1'b1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat == LAT_W'(DATA_W)));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);

  assert_busy_ends_with_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid);

  assert_idle_at_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy);

  assert_mag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_mag) |-> out_valid);

  assert_mag_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mag[DATA_W-1 -: SH_AC] == '0));
endmodule

bind spec_mag_norm spec_mag_norm_chk #(.DATA_W(DATA_W), .N_LOG2(N_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
  .out_valid(out_valid), .out_mag(out_mag)
);

// File: tb/spec_mag_norm_bench.sv
module spec_mag_norm_bench;
  localparam int DATA_W = 32;
  localparam int N_LOG2 = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DATA_W-1:0] in_re = '0, in_im = '0;
  logic [N_LOG2-1:0] in_bin = '0;
  logic busy, out_valid;
  logic [DATA_W-1:0] out_mag;

  always #2.5 clk = ~clk;

  spec_mag_norm #(.DATA_W(DATA_W), .N_LOG2(N_LOG2)) u_spec_mag_norm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .in_bin(in_bin), .busy(busy), .out_valid(out_valid), .out_mag(out_mag)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DATA_W-1:0] exp_q[$];
  string tag_q[$];
  int acc_q[$];
  int out_t[$];
  logic [DATA_W-1:0] last_mag = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [DATA_W-1:0] model(input logic signed [DATA_W-1:0] re,
      input logic signed [DATA_W-1:0] im, input logic [N_LOG2-1:0] bin);
    logic signed [63:0] r64, i64;
    logic [63:0] s, r, t;
    r64 = re; i64 = im;
    s = r64 * r64 + i64 * i64;
    r = 0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      t = r | (64'd1 << b);
      if (t * t <= s) r = t;
    end
    return (bin == 0) ? DATA_W'(r >> N_LOG2) : DATA_W'(r >> (N_LOG2 - 1));
  endfunction

  task automatic send(input logic signed [DATA_W-1:0] re, input logic signed [DATA_W-1:0] im,
      input logic [N_LOG2-1:0] bin, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    in_re = re; in_im = im; in_bin = bin; in_valid = 1'b1;
    exp_q.push_back(model(re, im, bin));
    tag_q.push_back(tag);
    acc_q.push_back(cyc + 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected result", out_mag, 0);
        end else begin
          logic [DATA_W-1:0] e;
          string tg;
          int a;
          e = exp_q.pop_front(); tg = tag_q.pop_front(); a = acc_q.pop_front();
          check(out_mag == e, tg, out_mag, e);
          check(cyc == a + DATA_W, "R4 latency", cyc - a, DATA_W);
        end
        out_t.push_back(cyc);
        last_mag = out_mag;
      end else begin
        check(out_mag == last_mag, "R8 hold", out_mag, last_mag);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(out_mag == '0, "R1 out_mag", out_mag, 0);
    rst_n = 1'b1;

    send(32'sd3 <<< 20, 32'sd4 <<< 20, 10'd5, "R2 3-4-5 bin5");
    drain();
    send(32'sd3 <<< 20, 32'sd4 <<< 20, 10'd0, "R3 3-4-5 dc");
    drain();
    send(-(32'sd3 <<< 20), 32'sd4 <<< 20, 10'd1023, "R2 negative re last bin");
    drain();
    send(32'sh80000000, 32'sh80000000, 10'd7, "R2 most negative pair");
    drain();
    send(32'sh80000000, 32'sh80000000, 10'd0, "R3 most negative pair dc");
    drain();
    send(32'sh7fffffff, 32'sd0, 10'd2, "R2 max real");
    drain();
    send(32'sd0, 32'sd0, 10'd0, "R3 zero dc");
    drain();
    send(32'sd0, -32'sd1000000, 10'd1, "R2 imaginary only");
    drain();

    send(32'sd100000000, 32'sd50000000, 10'd9, "R6 bin captured");
    @(negedge clk);
    check(busy == 1'b1, "R5 busy during compute", busy, 1);
    in_valid = 1'b1; in_re = 32'sd7; in_im = -32'sd9; in_bin = 10'd0;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    drain();
    check(exp_q.size() == 0, "R5 no extra result", exp_q.size(), 0);

    send(32'sd123456789, -32'sd987654321, 10'd3, "R7 first");
    send(-32'sd55555555, 32'sd44444444, 10'd0, "R7 second");
    drain();
    check(out_t[out_t.size()-1] - out_t[out_t.size()-2] == DATA_W + 1, "R7 spacing",
          out_t[out_t.size()-1] - out_t[out_t.size()-2], DATA_W + 1);

    for (int i = 0; i < 30; i++) begin
      logic [N_LOG2-1:0] b;
      b = (i % 4 == 0) ? '0 : N_LOG2'($urandom);
      send($signed($urandom), $signed($urandom), b, (b == 0) ? "R3 random dc" : "R2 random");
    end
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule